// File: doc/BRIEF.md
# Hysteretic Automatic Gain Controller

This block closes the digital side of an automatic gain control loop. It watches signed samples from the ADC that follows a programmable-gain amplifier and adjusts a small gain code for that amplifier. The adjustment is asymmetric. A large sample cuts the gain by one step on that same sample. The gain rises by one step only after the signal has stayed small for a fixed window of about 2 ms, counted in valid samples.

Every real change of the gain code also raises a one-cycle strobe. Downstream tone and data detectors use this strobe to abandon a measurement that was taken across a gain step. The amplifier and the converter are outside this block. The gain code covers a span of roughly 35 dB in 32 settings.

Top module: `agc_gain_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the gain code is the maximum value 31 and the change strobe is low, until the first valid sample is taken.
- R2: A valid sample whose magnitude is greater than 7/8 of full scale (magnitude 113 to 128 for 8-bit two's-complement samples, so -128 counts as 128) lowers the gain code by one. The new code is visible in the cycle after the sample.
- R3: At gain code 0, a loud sample leaves the code at 0 and raises no strobe.
- R4: When QUIET_N consecutive valid samples all have magnitude below 1/4 of full scale (below 32), the gain code rises by one on the last of them, and the quiet count starts again from zero. QUIET_N is the sample rate times 2 ms; the default is 32.
- R5: A valid sample with magnitude from 32 to 112 inclusive leaves the gain unchanged and restarts the quiet count.
- R6: At gain code 31, a completed quiet window leaves the code at 31 and raises no strobe.
- R7: The change strobe is high for exactly the one cycle in which a new gain code first appears, and it is low in every other cycle.
- R8: Cycles without the sample-valid strobe are ignored. The value on the sample input in those cycles changes neither the gain nor the quiet count, and it does not break a quiet run.
- R9: The gain code moves by at most one step per cycle and never wraps between 0 and 31.
- R10: A loud sample also restarts the quiet count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| smp_valid_i | input | 1 | High when a new sample is present on smp_i |
| smp_i | input | 8 | ADC sample, signed two's complement |
| gain_o | output | 5 | Gain code for the amplifier; 31 is the highest gain |
| gain_chg_o | output | 1 | One-cycle strobe marking a change of gain_o |

## Verification
The bound checker tests several rules on every clock cycle: the single-step, no-wrap movement of the gain code; that the strobe matches an actual change of the code; that idle cycles raise no strobe; the one-step drop after a loud sample; and that mid-level samples hold the gain. The rise after a full quiet window is left to the bench, and so is the way a mid or loud sample, or a gap in the valid strobe, affects that window. These behaviours depend on how many samples came before, so the bench checks them with directed runs of exactly QUIET_N-1 and QUIET_N quiet samples and with a cycle-by-cycle reference model under random traffic.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    LVL_QUIET = 2'd0,
    LVL_MID   = 2'd1,
    LVL_LOUD  = 2'd2
  } agc_lvl_e;
endpackage

// File: rtl/agc_rst_sync.sv
module agc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/agc_level_classify.sv
module agc_level_classify
  import agc_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic [SAMPLE_W-1:0] smp,
  output agc_lvl_e            lvl
);
  localparam int FULL  = 1 << (SAMPLE_W - 1);
  localparam int HI_TH = (FULL * 7) / 8;
  localparam int LO_TH = FULL / 4;
  localparam logic [SAMPLE_W-1:0] HI_V = SAMPLE_W'(HI_TH);
  localparam logic [SAMPLE_W-1:0] LO_V = SAMPLE_W'(LO_TH);
  localparam logic [SAMPLE_W-1:0] ONE  = SAMPLE_W'(1);

  logic [SAMPLE_W-1:0] mag;

  // Magnitude as unsigned; the most negative code maps to full scale.
  always_comb begin
    if (smp[SAMPLE_W-1]) mag = (~smp) + ONE;
    else                 mag = smp;
  end

  always_comb begin
    if (mag > HI_V)       lvl = LVL_LOUD;
    else if (mag < LO_V)  lvl = LVL_QUIET;
    else                  lvl = LVL_MID;
  end
endmodule

// File: rtl/agc_quiet_timer.sv
module agc_quiet_timer #(
  parameter int QUIET_N = 32,
  parameter int CNT_W   = (QUIET_N > 1) ? $clog2(QUIET_N) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic quiet,
  output logic expire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUIET_N - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expire = smp_en && quiet && (cnt_q == LAST);
  assign cnt_en = smp_en;

  always_comb begin
    if (!quiet || expire) cnt_d = '0;
    else                  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/agc_gain_step.sv
module agc_gain_step #(
  parameter int GAIN_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_req,
  input  logic              inc_req,
  output logic [GAIN_W-1:0] gain,
  output logic              chg
);
  localparam logic [GAIN_W-1:0] G_MAX = '1;
  localparam logic [GAIN_W-1:0] G_ONE = GAIN_W'(1);

  logic [GAIN_W-1:0] gain_q, gain_d;
  logic              chg_q, chg_d;
  logic              gain_en;

  // Attack has priority over release.
  always_comb begin
    gain_d = gain_q;
    chg_d  = 1'b0;
    if (dec_req) begin
      if (gain_q != '0) begin
        gain_d = gain_q - G_ONE;
        chg_d  = 1'b1;
      end
    end else if (inc_req) begin
      if (gain_q != G_MAX) begin
        gain_d = gain_q + G_ONE;
        chg_d  = 1'b1;
      end
    end
  end

  assign gain_en = chg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gain_q <= G_MAX;
    else if (gain_en) gain_q <= gain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= 1'b0;
    else        chg_q <= chg_d;
  end

  assign gain = gain_q;
  assign chg  = chg_q;
endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
  import agc_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int GAIN_W    = 5,
  parameter int SAMPLE_HZ = 16000,
  parameter int HOLD_US   = 2000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  output logic [GAIN_W-1:0]   gain_o,
  output logic                gain_chg_o
);
  localparam int QUIET_RAW = (SAMPLE_HZ / 1000) * HOLD_US / 1000;
  localparam int QUIET_N   = (QUIET_RAW < 1) ? 1 : QUIET_RAW;

  logic     rst_sync_n;
  agc_lvl_e lvl;
  logic     is_loud, is_quiet, quiet_expire;

  agc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  agc_level_classify #(.SAMPLE_W(SAMPLE_W)) u_lvl (
    .smp (smp_i),
    .lvl (lvl)
  );

  assign is_loud  = smp_valid_i && (lvl == LVL_LOUD);
  assign is_quiet = (lvl == LVL_QUIET);

  agc_quiet_timer #(.QUIET_N(QUIET_N)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .smp_en (smp_valid_i),
    .quiet  (is_quiet),
    .expire (quiet_expire)
  );

  agc_gain_step #(.GAIN_W(GAIN_W)) u_step (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .dec_req (is_loud),
    .inc_req (quiet_expire),
    .gain    (gain_o),
    .chg     (gain_chg_o)
  );
endmodule

// File: rtl/agc_gain_ctrl_chk.sv
module agc_gain_ctrl_chk #(
  parameter int SAMPLE_W = 8,
  parameter int GAIN_W   = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid_i,
  input logic [SAMPLE_W-1:0] smp_i,
  input logic [GAIN_W-1:0]   gain_o,
  input logic                gain_chg_o
);
  localparam int FULL = 1 << (SAMPLE_W - 1);
  localparam logic [SAMPLE_W:0] HI_V = (SAMPLE_W+1)'((FULL * 7) / 8);
  localparam logic [SAMPLE_W:0] LO_V = (SAMPLE_W+1)'(FULL / 4);
  localparam logic [GAIN_W-1:0] G_MAX = '1;
  localparam logic [GAIN_W-1:0] G_ONE = GAIN_W'(1);

  logic [SAMPLE_W:0] smp_ext, mag_w;
  assign smp_ext = {smp_i[SAMPLE_W-1], smp_i};
  assign mag_w   = smp_i[SAMPLE_W-1] ? (~smp_ext + (SAMPLE_W+1)'(1)) : smp_ext;

  p_loud_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && (mag_w > HI_V) && (gain_o != '0)) |=> (gain_o == $past(gain_o) - G_ONE));

  p_floor_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_o == '0) |=> (gain_o <= G_ONE));

  p_mid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && (mag_w >= LO_V) && (mag_w <= HI_V)) |=> $stable(gain_o));

  p_ceiling_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_o == G_MAX) |=> (gain_o >= G_MAX - G_ONE));

  p_strobe_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gain_chg_o == (gain_o != $past(gain_o)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid_i |=> (!gain_chg_o && $stable(gain_o)));

  p_single_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_o == $past(gain_o)) || (gain_o == $past(gain_o) + G_ONE) ||
    (gain_o == $past(gain_o) - G_ONE));
endmodule

bind agc_gain_ctrl agc_gain_ctrl_chk #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .smp_valid_i (smp_valid_i),
  .smp_i       (smp_i),
  .gain_o      (gain_o),
  .gain_chg_o  (gain_chg_o)
);

// File: tb/sim_agc_gain_ctrl.sv
`timescale 1ns/1ps
module sim_agc_gain_ctrl;
  localparam int QN = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid_i = 1'b0;
  logic [7:0] smp_i = 8'd0;
  logic [4:0] gain_o;
  logic       gain_chg_o;

  int n_cmp = 0;
  int n_bad = 0;
  int m_gain = 31;
  int m_cnt = 0;
  bit m_chg = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  agc_gain_ctrl #(.SAMPLE_W(8), .GAIN_W(5), .SAMPLE_HZ(16000), .HOLD_US(2000)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .smp_i(smp_i),
    .gain_o(gain_o), .gain_chg_o(gain_chg_o)
  );

  function automatic int mag_of(logic [7:0] s);
    int v;
    v = $signed(s);
    return (v < 0) ? -v : v;
  endfunction

  // 0 quiet, 1 mid, 2 loud
  function automatic int class_of(logic [7:0] s);
    int m;
    m = mag_of(s);
    if (m > 112) return 2;
    if (m < 32)  return 0;
    return 1;
  endfunction

  task automatic model(bit v, logic [7:0] s);
    int c;
    m_chg = 1'b0;
    if (!v) return;
    c = class_of(s);
    if (c == 2) begin
      m_cnt = 0;
      if (m_gain > 0) begin m_gain--; m_chg = 1'b1; end
    end else if (c == 1) begin
      m_cnt = 0;
    end else if (m_cnt == QN - 1) begin
      m_cnt = 0;
      if (m_gain < 31) begin m_gain++; m_chg = 1'b1; end
    end else begin
      m_cnt++;
    end
  endtask

  task automatic check(string tag);
    n_cmp++;
    if (gain_o !== 5'(m_gain)) begin
      n_bad++;
      $display("FAIL %s gain: actual=%0d expected=%0d", tag, gain_o, m_gain);
    end
    n_cmp++;
    if (gain_chg_o !== m_chg) begin
      n_bad++;
      $display("FAIL %s strobe: actual=%0b expected=%0b", tag, gain_chg_o, m_chg);
    end
  endtask

  // Called just after a negedge: drive, take the edge, compare 1 ns later.
  task automatic step(bit v, logic [7:0] s, string tag);
    smp_valid_i = v;
    smp_i = s;
    @(posedge clk);
    #1;
    model(v, s);
    check(tag);
    @(negedge clk);
  endtask

  function automatic logic [7:0] rnd_of(int c);
    int m;
    int r;
    if (c == 0)      m = $urandom_range(31, 0);
    else if (c == 1) m = $urandom_range(112, 32);
    else             m = $urandom_range(128, 113);
    r = ($urandom_range(1, 0) == 1) ? -m : m;
    return 8'(r);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1");

    // Ceiling: a full quiet window at 31 must not move or strobe.
    for (int i = 0; i < QN; i++) step(1'b1, 8'(i % 32), "R6");

    // Boundaries around the thresholds, all non-loud.
    step(1'b1, 8'd112, "R5");
    step(1'b1, 8'h90,  "R5");  // -112
    step(1'b1, 8'd32,  "R5");
    step(1'b1, 8'hE0,  "R5");  // -32

    // Attack down to the floor with assorted loud values.
    step(1'b1, 8'd113, "R2");
    step(1'b1, 8'h80,  "R2");  // -128
    step(1'b1, 8'h8F,  "R2");  // -113
    for (int i = 0; i < 28; i++) step(1'b1, 8'd127, "R2");
    for (int i = 0; i < 3; i++)  step(1'b1, 8'h80, "R3");

    // Quiet run broken by a mid sample: no rise until a fresh full window.
    for (int i = 0; i < QN - 1; i++) step(1'b1, 8'd31, "R5");
    step(1'b1, 8'd40, "R5");
    for (int i = 0; i < QN - 1; i++) step(1'b1, 8'hE1, "R4");  // -31
    step(1'b1, 8'd0, "R4");

    // Idle cycles carry loud values and do not break the quiet run.
    for (int i = 0; i < QN; i++) begin
      step(1'b0, 8'h80, "R8");
      step(1'b1, 8'd5, "R8");
    end

    // Loud sample restarts the window.
    for (int i = 0; i < 20; i++) step(1'b1, 8'd3, "R10");
    step(1'b1, 8'd120, "R10");
    for (int i = 0; i < QN; i++) step(1'b1, 8'd3, "R10");

    // Random traffic, mostly quiet so releases happen.
    for (int i = 0; i < 6000; i++) begin
      int p;
      int c;
      p = $urandom_range(99, 0);
      c = (p < 90) ? 0 : ((p < 96) ? 1 : 2);
      step($urandom_range(9, 0) < 7, rnd_of(c), (i % 2 == 0) ? "R7" : "R9");
    end

    // Reset in mid operation brings back the maximum code.
    rst_n = 1'b0;
    #1;
    m_gain = 31; m_cnt = 0; m_chg = 1'b0;
    check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule